// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block runs a single read transaction against a small-page NAND flash device with an 8-bit bus. A start request carries a block number, a page index within that block and a mode bit. The mode bit selects either a whole main-area page or the single spare-area byte that holds the bad-block marker. The block first writes a command byte with the command latch raised. It then writes three or four address bytes with the address latch raised. Next it waits until the device has finished fetching the page. After that it strobes the bytes out one at a time and hands each to a valid/ready stream. A one-cycle done pulse closes the transaction.

The wait after the address phase takes one of two forms, chosen per request. When the device's ready/busy line is wired, the block first lets a fixed settle delay pass so that the device can pull the line low. It then waits until the synchronised line reads ready. When the line is not wired, the block waits a fixed timeout instead and ignores the line. Write-strobe widths, read-strobe widths, the settle delay and the timeout are parameters counted in clock cycles. Page size, pages per block, the marker column and the number of address cycles are parameters as well.

Top module: `nand_rd_seq`

## Requirements
- R1: Each transaction writes exactly one command byte with nand_cle high and nand_ale low: 8'h00 in page mode (mode_spare=0), 8'h50 in spare mode (mode_spare=1).
- R2: The address bytes are written with nand_ale high and nand_cle low, in this order: the column byte, then page address bits 7:0, then bits 15:8. When FOUR_CYCLE is 1, a fourth byte {4'h0, bits 19:16} follows. The column byte is 0 in page mode and BB_POS in spare mode. nand_ale falls after the last byte, and nand_cle and nand_ale are never high together.
- R3: The page address equals blk_num * PAGES_PER_BLOCK + page_idx.
- R4: Each written byte gets one nand_we_n low pulse of exactly WE_LOW_CLK cycles, and nand_dq_o is driven and unchanged when nand_we_n rises.
- R5: With rb_wired=1, nand_re_n does not fall within TWB_CLK cycles of the fall of nand_ale. The first fall of nand_re_n comes no earlier than 4 clock periods after nand_rb_n rises, because nand_rb_n passes through two flops.
- R6: With rb_wired=0, nand_rb_n is ignored, and the first fall of nand_re_n comes exactly TIMEOUT_CLK+1 cycles after the fall of nand_ale.
- R7: Page mode delivers exactly PAGE_SIZE bytes and spare mode exactly one. Each byte is the nand_dq_i value present when nand_re_n rises, and each nand_re_n low pulse lasts exactly RE_LOW_CLK cycles.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. nand_re_n does not fall while a byte is waiting.
- R9: After reset, busy, done and out_valid are low, nand_we_n and nand_re_n are high, and nand_cle, nand_ale and nand_dq_oe are low. busy rises the cycle after an accepted start and stays high through the one-cycle done pulse. It is low on the cycle after done.
- R10: A start asserted while busy is high has no effect on the running transaction and does not begin another one.
- R11: nand_dq_oe is high only while nand_cle or nand_ale is high, and never while nand_re_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transaction (taken only when idle) |
| mode_spare | input | 1 | 0: main-area page read, 1: spare marker byte read |
| blk_num | input | BLK_W | Block number |
| page_idx | input | $clog2(PAGES_PER_BLOCK) | Page within the block |
| rb_wired | input | 1 | 1: wait on ready/busy, 0: wait fixed timeout |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Read byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus value driven towards the device |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus value from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The ready-gate check on the first read strobe assumes two things about nand_rb_n. The line must not drop back to busy once it has reported ready for a transaction, and the device must pull it low within the settle delay after the address latch falls. The stimulus drives the line low one cycle after nand_ale falls, well inside the settle delay. It holds the line high from its release until the next request, and in timeout mode it keeps the line low for the whole transaction. The stream hold check assumes nothing about out_ready. The stimulus throttles out_ready with a pseudo-random pattern on half of the transactions and keeps it high on the rest.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_SETTLE,
    ST_RBWAIT,
    ST_TMO,
    ST_READ,
    ST_HOLD,
    ST_DONE
  } rd_state_e;

  localparam logic [7:0] OP_READ_MAIN  = 8'h00;
  localparam logic [7:0] OP_READ_SPARE = 8'h50;

  // Linear page number from block number and page-in-block index.
  function automatic logic [19:0] calc_page_addr(input logic [31:0] blk,
                                                 input logic [31:0] idx,
                                                 input int unsigned ppb);
    logic [31:0] full;
    full = blk * ppb + idx;
    return full[19:0];
  endfunction

  // Byte sent on address cycle number sel.
  function automatic logic [7:0] addr_cycle_byte(input logic [1:0]  sel,
                                                 input logic [7:0]  col,
                                                 input logic [19:0] pa);
    case (sel)
      2'd0:    return col;
      2'd1:    return pa[7:0];
      2'd2:    return pa[15:8];
      default: return {4'h0, pa[19:16]};
    endcase
  endfunction

endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_async,
  output logic rb_ready_s
);
  logic meta_q;

  // Both flops reset to "busy" so nothing reads as ready straight out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rb_ready_s <= 1'b0;
    end else begin
      meta_q     <= rb_n_async;
      rb_ready_s <= meta_q;
    end
  end
endmodule

// File: rtl/nand_we_pulse.sv
module nand_we_pulse #(
  parameter int LOW_CLK  = 2,
  parameter int HIGH_CLK = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic we_n,
  output logic beat_end
);
  localparam int TOT = LOW_CLK + HIGH_CLK;
  localparam int CW  = $clog2(TOT + 1);

  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      we_n   <= 1'b1;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        we_n   <= 1'b0;
      end
    end else begin
      if (cnt == CW'(LOW_CLK - 1)) we_n <= 1'b1;
      if (cnt == CW'(TOT - 1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign beat_end = active && (cnt == CW'(TOT - 1));

  AST_WE_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |-> we_n); // R4
endmodule

// File: rtl/nand_re_sample.sv
module nand_re_sample #(
  parameter int LOW_CLK  = 2,
  parameter int HIGH_CLK = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] dq_i,
  output logic       re_n,
  output logic       beat_end,
  output logic [7:0] rd_byte
);
  localparam int TOT = LOW_CLK + HIGH_CLK;
  localparam int CW  = $clog2(TOT + 1);

  logic          active;
  logic [CW-1:0] cnt;

  // The byte is captured on the same edge that releases the strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      re_n    <= 1'b1;
      rd_byte <= 8'h00;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        re_n   <= 1'b0;
      end
    end else begin
      if (cnt == CW'(LOW_CLK - 1)) begin
        re_n    <= 1'b1;
        rd_byte <= dq_i;
      end
      if (cnt == CW'(TOT - 1)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign beat_end = active && (cnt == CW'(TOT - 1));

  AST_RE_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (re_n && $past(re_n)) |-> $stable(rd_byte)); // R7
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int PAGE_SIZE       = 512,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int BLK_W           = 15,
  parameter bit FOUR_CYCLE      = 1'b0,
  parameter int BB_POS          = 5,
  parameter int WE_LOW_CLK      = 2,
  parameter int WE_HIGH_CLK     = 2,
  parameter int RE_LOW_CLK      = 2,
  parameter int RE_HIGH_CLK     = 2,
  parameter int TWB_CLK         = 4,
  parameter int TIMEOUT_CLK     = 200,
  localparam int PIDX_W         = $clog2(PAGES_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_spare,
  input  logic [BLK_W-1:0]  blk_num,
  input  logic [PIDX_W-1:0] page_idx,
  input  logic              rb_wired,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb_n
);
  localparam int          BC_W      = $clog2(PAGE_SIZE);
  localparam int          WT_MAX    = (TWB_CLK > TIMEOUT_CLK) ? TWB_CLK : TIMEOUT_CLK;
  localparam int          WT_W      = $clog2(WT_MAX + 1);
  localparam logic [1:0]  LAST_ADDR = FOUR_CYCLE ? 2'd3 : 2'd2;
  localparam logic [7:0]  SPARE_COL = 8'(BB_POS);

  rd_state_e         state;
  logic              spare_q;
  logic              rbw_q;
  logic [19:0]       pa_q;
  logic [1:0]        addr_idx;
  logic [WT_W-1:0]   wcnt;
  logic [BC_W-1:0]   byte_cnt;

  // Named internal events.
  logic              wr_go, wr_end;
  logic              rd_go, rd_end;
  logic              addr_last;
  logic              settle_hit, tmo_hit;
  logic              xfer;
  logic              rb_ready_s;
  logic [7:0]        rd_byte;
  logic [BC_W-1:0]   last_idx;
  logic [7:0]        col_byte;
  logic [7:0]        cmd_byte;

  assign wr_go      = (state == ST_CMD) || (state == ST_ADDR);
  assign rd_go      = (state == ST_READ);
  assign addr_last  = (addr_idx == LAST_ADDR);
  assign settle_hit = (wcnt == WT_W'(TWB_CLK - 1));
  assign tmo_hit    = (wcnt == WT_W'(TIMEOUT_CLK - 1));
  assign xfer       = out_valid && out_ready;
  assign last_idx   = spare_q ? '0 : BC_W'(PAGE_SIZE - 1);
  assign col_byte   = spare_q ? SPARE_COL : 8'h00;
  assign cmd_byte   = spare_q ? OP_READ_SPARE : OP_READ_MAIN;

  nand_rb_sync u_rb_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rb_n_async (nand_rb_n),
    .rb_ready_s (rb_ready_s)
  );

  nand_we_pulse #(
    .LOW_CLK  (WE_LOW_CLK),
    .HIGH_CLK (WE_HIGH_CLK)
  ) u_we (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (wr_go),
    .we_n     (nand_we_n),
    .beat_end (wr_end)
  );

  nand_re_sample #(
    .LOW_CLK  (RE_LOW_CLK),
    .HIGH_CLK (RE_HIGH_CLK)
  ) u_re (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (rd_go),
    .dq_i     (nand_dq_i),
    .re_n     (nand_re_n),
    .beat_end (rd_end),
    .rd_byte  (rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      spare_q  <= 1'b0;
      rbw_q    <= 1'b0;
      pa_q     <= '0;
      addr_idx <= '0;
      wcnt     <= '0;
      byte_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            spare_q  <= mode_spare;
            rbw_q    <= rb_wired;
            pa_q     <= calc_page_addr(32'(blk_num), 32'(page_idx), PAGES_PER_BLOCK);
            addr_idx <= '0;
            byte_cnt <= '0;
            state    <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (wr_end) state <= ST_ADDR;
        end
        ST_ADDR: begin
          if (wr_end) begin
            if (addr_last) begin
              wcnt  <= '0;
              state <= rbw_q ? ST_SETTLE : ST_TMO;
            end else begin
              addr_idx <= addr_idx + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_hit) state <= ST_RBWAIT;
          else            wcnt  <= wcnt + 1'b1;
        end
        ST_RBWAIT: begin
          if (rb_ready_s) state <= ST_READ;
        end
        ST_TMO: begin
          if (tmo_hit) state <= ST_READ;
          else         wcnt  <= wcnt + 1'b1;
        end
        ST_READ: begin
          if (rd_end) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (out_ready) begin
            if (byte_cnt == last_idx) begin
              state <= ST_DONE;
            end else begin
              byte_cnt <= byte_cnt + 1'b1;
              state    <= ST_READ;
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign out_valid  = (state == ST_HOLD);
  assign out_data   = rd_byte;
  assign nand_cle   = (state == ST_CMD);
  assign nand_ale   = (state == ST_ADDR);
  assign nand_dq_oe = wr_go;
  assign nand_dq_o  = (state == ST_CMD)  ? cmd_byte :
                      (state == ST_ADDR) ? addr_cycle_byte(addr_idx, col_byte, pa_q) :
                                           8'h00;

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2
  AST_WE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (nand_dq_oe && $stable(nand_dq_o))); // R4
  AST_RB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rbw_q && $fell(nand_re_n) && (byte_cnt == '0)) |-> rb_ready_s); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_NO_RE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> nand_re_n); // R8
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(pa_q)); // R10
  AST_BUS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_dq_oe && !nand_re_n)); // R11
  AST_XFER_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> busy); // R8
endmodule

// File: tb/nand_rd_seq_tb.sv
`timescale 1ns/1ps
module nand_rd_seq_tb;
  localparam int  PS   = 8;
  localparam int  PPB  = 4;
  localparam int  BLKW = 18;
  localparam int  BBP  = 5;
  localparam int  WEL  = 2;
  localparam int  WEH  = 1;
  localparam int  REL  = 2;
  localparam int  REH  = 1;
  localparam int  TWB  = 3;
  localparam int  TMO  = 20;
  localparam real CLKP = 5.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            start = 1'b0, mode_spare = 1'b0, rb_wired = 1'b0, out_ready = 1'b0;
  logic [BLKW-1:0] blk_num = '0;
  logic [1:0]      page_idx = '0;
  logic            busy, done, out_valid;
  logic [7:0]      out_data;
  logic            nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]      nand_dq_o;
  logic [7:0]      dq_i = 8'h00;
  logic            rb_n = 1'b1;

  int checks = 0;
  int errors = 0;

  nand_rd_seq #(
    .PAGE_SIZE(PS), .PAGES_PER_BLOCK(PPB), .BLK_W(BLKW), .FOUR_CYCLE(1'b1),
    .BB_POS(BBP), .WE_LOW_CLK(WEL), .WE_HIGH_CLK(WEH), .RE_LOW_CLK(REL),
    .RE_HIGH_CLK(REH), .TWB_CLK(TWB), .TIMEOUT_CLK(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_spare(mode_spare),
    .blk_num(blk_num), .page_idx(page_idx), .rb_wired(rb_wired),
    .busy(busy), .done(done), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(dq_i), .nand_rb_n(rb_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Device content model: a byte depends on page and column.
  function automatic logic [7:0] exp_byte(input logic [19:0] pa, input int col);
    return (pa[7:0] ^ pa[15:8] ^ {4'h0, pa[19:16]}) + 8'(col * 37) + 8'h11;
  endfunction

  // Device-side capture
  logic [7:0] cmd_seen;
  logic [7:0] alog [0:7];
  int         ncmd, naddr, rd_ptr, oe_bad;
  realtime    we_fall_t, re_fall_t, ale_fall_t, rb_rise_t, first_re_t;
  bit         first_re_done;

  function automatic logic [19:0] dev_pa();
    return {alog[3][3:0], alog[2], alog[1]};
  endfunction

  always @(negedge nand_we_n) if (rst_n) we_fall_t = $realtime;
  always @(posedge nand_we_n) if (rst_n) begin
    chk(int'(($realtime - we_fall_t) / CLKP) == WEL, "R4", "WE low width",
        int'(($realtime - we_fall_t) / CLKP), WEL);
    if (nand_cle) begin
      cmd_seen = nand_dq_o;
      ncmd++;
    end else if (nand_ale) begin
      if (naddr < 8) alog[naddr] = nand_dq_o;
      naddr++;
    end
  end
  always @(negedge nand_ale) if (rst_n) ale_fall_t = $realtime;
  always @(negedge nand_re_n) if (rst_n) begin
    re_fall_t = $realtime;
    if (!first_re_done) begin
      first_re_t    = $realtime;
      first_re_done = 1'b1;
    end
    chk(!out_valid, "R8", "RE fell while byte pending", out_valid, 0);
    dq_i = exp_byte(dev_pa(), int'(alog[0]) + rd_ptr);
    rd_ptr++;
  end
  always @(posedge nand_re_n) if (rst_n)
    chk(int'(($realtime - re_fall_t) / CLKP) == REL, "R7", "RE low width",
        int'(($realtime - re_fall_t) / CLKP), REL);
  always @(negedge clk) if (rst_n && nand_dq_oe && !(nand_cle || nand_ale)) oe_bad++;

  logic [7:0] lfsr = 8'hA5;

  task automatic run_tx(input int blk, input int pg, input bit spare, input bit rbw,
                        input int busyc, input bit throttle);
    logic [19:0] pa;
    int          nexp, col0, ngot, ndone;
    logic [7:0]  got [0:PS-1];
    pa    = 20'(blk * PPB + pg);
    nexp  = spare ? 1 : PS;
    col0  = spare ? BBP : 0;
    ngot  = 0;
    ndone = 0;
    ncmd = 0; naddr = 0; rd_ptr = 0; first_re_done = 1'b0; oe_bad = 0;
    rb_n = rbw;
    @(negedge clk);
    blk_num = BLKW'(blk); page_idx = 2'(pg); mode_spare = spare; rb_wired = rbw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9", "busy after start", busy, 1);
    fork
      begin
        if (rbw) begin
          @(negedge nand_ale);
          @(posedge clk); #1 rb_n = 1'b0;
          repeat (busyc) @(posedge clk);
          #1 rb_n = 1'b1;
          rb_rise_t = $realtime;
        end
      end
      begin
        int cyc;
        bit fin;
        cyc = 0;
        fin = 1'b0;
        while (!fin) begin
          @(negedge clk);
          cyc++;
          // R10: request with another address while busy
          if (cyc == 6) begin
            blk_num = BLKW'(blk + 3); mode_spare = !spare; start = 1'b1;
          end else begin
            start = 1'b0;
          end
          if (done) begin
            ndone++;
            fin = 1'b1;
            out_ready = 1'b0;
          end else begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = throttle ? (lfsr[0] | lfsr[2]) : 1'b1;
            if (out_valid && out_ready) begin
              if (ngot < PS) got[ngot] = out_data;
              ngot++;
            end
          end
          if (cyc > 5000) fin = 1'b1;
        end
      end
    join
    start = 1'b0;
    @(negedge clk);
    chk(!busy, "R9", "busy after done", busy, 0);
    chk(ndone == 1, "R9", "done pulses", ndone, 1);
    chk(ncmd == 1, "R10", "command writes", ncmd, 1);
    chk(cmd_seen == (spare ? 8'h50 : 8'h00), "R1", "command byte", cmd_seen, spare ? 8'h50 : 8'h00);
    chk(naddr == 4, "R2", "address writes", naddr, 4);
    chk(alog[0] == 8'(col0), "R2", "column byte", alog[0], col0);
    chk(alog[1] == pa[7:0], "R3", "addr byte 1", alog[1], pa[7:0]);
    chk(alog[2] == pa[15:8], "R3", "addr byte 2", alog[2], pa[15:8]);
    chk(alog[3] == {4'h0, pa[19:16]}, "R2", "addr byte 3", alog[3], {4'h0, pa[19:16]});
    chk(ngot == nexp, "R7", "byte count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      chk(got[i] == exp_byte(pa, col0 + i), "R7", "data byte", got[i], exp_byte(pa, col0 + i));
    if (rbw) begin
      chk(int'((first_re_t - ale_fall_t) / CLKP) >= TWB + 1, "R5", "ALE to RE cycles",
          int'((first_re_t - ale_fall_t) / CLKP), TWB + 1);
      chk(int'((first_re_t - rb_rise_t) / CLKP) >= 4, "R5", "ready to RE cycles",
          int'((first_re_t - rb_rise_t) / CLKP), 4);
    end else begin
      chk(int'((first_re_t - ale_fall_t) / CLKP) == TMO + 1, "R6", "timeout cycles",
          int'((first_re_t - ale_fall_t) / CLKP), TMO + 1);
    end
    chk(oe_bad == 0, "R11", "bus driven outside latch phases", oe_bad, 0);
    rb_n = 1'b1;
  endtask

  initial begin
    int blks [7];
    blks = '{0, 1, 5, 'h3FFFF, 'h10000, 'h2ABCD, 'h00FFF};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid, "R9", "reset status", {busy, done, out_valid}, 0);
    chk(nand_we_n && nand_re_n, "R9", "reset strobes", {nand_we_n, nand_re_n}, 3);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R11", "reset latches",
        {nand_cle, nand_ale, nand_dq_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int b = 0; b < 7; b++)
      for (int p = 0; p < PPB; p++)
        for (int m = 0; m < 2; m++)
          run_tx(blks[b], p, m[0], ((b + p) % 2) == 1, 2 + ((b * 3 + p) % 6), ((b + m) % 2) == 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule